// File: doc/BRIEF.md
# Ticket-Claim Hardware Lock

This block lets several bus agents share one resource by means of two 32-bit registers behind a common register port. The ticket register hands out a number on every read. That number is unique and never zero. The lock register is free while it holds zero and held while it holds anything else.

An agent claims the lock in three steps. It reads a ticket, writes that ticket into the lock register, and reads the lock register back. It owns the lock only if the value it reads back equals its own ticket. It frees the lock by writing zero. If the read-back does not match, the agent tries again. Software keeps the retry count bounded, up to 4096 attempts, before it gives up with a busy result.

Several requesters share the port. A fixed-priority arbiter accepts one access per cycle. A requester that is not granted keeps its request asserted until it is granted.

Top module: `tktlock_top`

## Requirements
- R1: After reset the ticket register holds 1, the lock register holds 0 and no read response is pending.
- R2: A read of offset 0x08 returns the current ticket. It then advances the ticket by one. No other access changes the ticket.
- R3: When the ticket is at its all-ones value (the width is set by a parameter), a read returns that value and the next ticket is 1. Zero is never issued.
- R4: A nonzero write to offset 0x0C while the lock register is zero stores the written value. A read of 0x0C returns that value.
- R5: A nonzero write to 0x0C while the lock register is nonzero is ignored. The held value stays in place.
- R6: A write of zero to 0x0C clears the lock register, whatever it held.
- R7: Among the asserted requests, only the lowest-numbered one sees its grant. Ungranted requests are held. When writes to 0x0C collide, the lower-numbered port is served first and therefore wins a free lock.
- R8: A granted read raises the read-valid bit of that port alone, exactly one cycle later, with the read data on the shared data output.
- R9: Reads of any offset other than 0x08 and 0x0C return 0. Writes to any offset other than 0x0C, including 0x08, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | Access request, one bit per port |
| wr | input | N_REQ | 1 = write, 0 = read, per port |
| offs | input | N_REQ*8 | Register byte offset per port, packed |
| wdata | input | N_REQ*32 | Write data per port, packed |
| gnt | output | N_REQ | Grant; the access is taken at the next clock edge |
| rvalid | output | N_REQ | Read response valid, per port |
| rdata | output | 32 | Read response data |

## Verification
Two things can fall in the same cycle: claim writes from more than one port, and a claim write from one port alongside another port's ticket or lock read. The bench provokes the first case by asserting all ports at once, each writing a distinct nonzero ticket to a free lock. It checks that the grants follow the port order, one per cycle, and that only the lowest port's value is kept. It provokes the second case with two agents whose claim sequences interleave. The agent that writes second must read back a mismatch. After a release, it must succeed on a later attempt.

// File: rtl/tktlock_pkg.sv
package tktlock_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;

    localparam logic [OFF_W-1:0] OFF_TICKET = 8'h08;
    localparam logic [OFF_W-1:0] OFF_LOCK   = 8'h0C;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [OFF_W-1:0]  offs;
        logic [DATA_W-1:0] data;
    } access_t;

    function automatic logic [DATA_W-1:0] lock_next(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wv);
        if (wv == '0)       return '0;
        else if (cur == '0) return wv;
        else                return cur;
    endfunction
endpackage

// File: rtl/tktlock_arb.sv
module tktlock_arb #(
    parameter int N_REQ = 3
) (
    input  logic             en,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    logic [N_REQ-1:0] blocked;

    for (genvar i = 0; i < N_REQ; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign blocked[i] = 1'b0;
        end else begin : g_rest
            assign blocked[i] = blocked[i-1] | req[i-1];
        end
    end

    assign gnt = req & ~blocked & {N_REQ{en}};
endmodule

// File: rtl/tktlock_ticket.sv
module tktlock_ticket #(
    parameter int TICKET_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    output logic [TICKET_W-1:0] ticket
);
    localparam logic [TICKET_W-1:0] ONE = {{(TICKET_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            ticket <= ONE;
        else if (advance)
            ticket <= (ticket == '1) ? ONE : ticket + ONE;
    end
endmodule

// File: rtl/tktlock_sem.sv
module tktlock_sem
    import tktlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wv,
    output logic [DATA_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (wr_en)
            value <= lock_next(value, wv);
    end
endmodule

// File: rtl/tktlock_top.sv
module tktlock_top
    import tktlock_pkg::*;
#(
    parameter int N_REQ    = 3,
    parameter int TICKET_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        req,
    input  logic [N_REQ-1:0]        wr,
    input  logic [N_REQ*OFF_W-1:0]  offs,
    input  logic [N_REQ*DATA_W-1:0] wdata,
    output logic [N_REQ-1:0]        gnt,
    output logic [N_REQ-1:0]        rvalid,
    output logic [DATA_W-1:0]       rdata
);
    access_t             acc;
    logic [TICKET_W-1:0] ticket_cur;
    logic [DATA_W-1:0]   lock_cur;
    logic                tick_rd;
    logic                lock_wr;
    logic [DATA_W-1:0]   rd_mux;

    tktlock_arb #(.N_REQ(N_REQ)) u_arb (
        .en  (!rst),
        .req (req),
        .gnt (gnt)
    );

    always_comb begin
        acc = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i]) begin
                acc.valid = 1'b1;
                acc.wr    = wr[i];
                acc.offs  = offs[i*OFF_W +: OFF_W];
                acc.data  = wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    assign tick_rd = acc.valid && !acc.wr && (acc.offs == OFF_TICKET);
    assign lock_wr = acc.valid &&  acc.wr && (acc.offs == OFF_LOCK);

    tktlock_ticket #(.TICKET_W(TICKET_W)) u_ticket (
        .clk     (clk),
        .rst     (rst),
        .advance (tick_rd),
        .ticket  (ticket_cur)
    );

    tktlock_sem u_sem (
        .clk   (clk),
        .rst   (rst),
        .wr_en (lock_wr),
        .wv    (acc.data),
        .value (lock_cur)
    );

    always_comb begin
        case (acc.offs)
            OFF_TICKET: rd_mux = DATA_W'(ticket_cur);
            OFF_LOCK:   rd_mux = lock_cur;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= '0;
            rdata  <= '0;
        end else begin
            rvalid <= gnt & ~wr;
            if (acc.valid && !acc.wr)
                rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/tktlock_chk.sv
module tktlock_chk #(
    parameter int N_REQ    = 3,
    parameter int TICKET_W = 32,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [N_REQ-1:0]    req,
    input logic [N_REQ-1:0]    wr,
    input logic [N_REQ-1:0]    gnt,
    input logic [N_REQ-1:0]    rvalid,
    input logic                acc_valid,
    input logic                acc_wr,
    input logic [7:0]          acc_offs,
    input logic [DATA_W-1:0]   acc_data,
    input logic [TICKET_W-1:0] ticket_cur,
    input logic [DATA_W-1:0]   lock_cur
);
    logic tick_rd_c, lock_clr_c, lock_wr_c;
    assign tick_rd_c  = acc_valid && !acc_wr && acc_offs == 8'h08;
    assign lock_wr_c  = acc_valid &&  acc_wr && acc_offs == 8'h0C;
    assign lock_clr_c = lock_wr_c && acc_data == '0;

    a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r7_grant_has_req: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        req[0] |-> gnt[0]);
    a_r8_rvalid_timing: assert property (@(posedge clk) disable iff (rst)
        rvalid == $past(gnt & ~wr));
    a_r3_ticket_nonzero: assert property (@(posedge clk) disable iff (rst)
        ticket_cur != '0);
    a_r2_ticket_quiet: assert property (@(posedge clk) disable iff (rst)
        !tick_rd_c |=> $stable(ticket_cur));
    a_r5_held_kept: assert property (@(posedge clk) disable iff (rst)
        (lock_cur != '0 && !lock_clr_c) |=> $stable(lock_cur));
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        lock_clr_c |=> lock_cur == '0);
    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !lock_wr_c |=> $stable(lock_cur));
endmodule

bind tktlock_top tktlock_chk #(
    .N_REQ(N_REQ), .TICKET_W(TICKET_W), .DATA_W(tktlock_pkg::DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .wr         (wr),
    .gnt        (gnt),
    .rvalid     (rvalid),
    .acc_valid  (acc.valid),
    .acc_wr     (acc.wr),
    .acc_offs   (acc.offs),
    .acc_data   (acc.data),
    .ticket_cur (ticket_cur),
    .lock_cur   (lock_cur)
);

// File: tb/tktlock_top_bench.sv
module tktlock_top_bench;
    localparam int N   = 3;
    localparam int TW  = 4;
    localparam logic [31:0] TMAX = (32'd1 << TW) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    wr = '0;
    logic [N*8-1:0]  offs = '0;
    logic [N*32-1:0] wdata = '0;
    logic [N-1:0]    gnt;
    logic [N-1:0]    rvalid;
    logic [31:0]     rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] m_tick;
    logic [31:0] m_lock;

    always #5 clk = ~clk;

    tktlock_top #(.N_REQ(N), .TICKET_W(TW)) u_tktlock_top (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .offs(offs),
        .wdata(wdata), .gnt(gnt), .rvalid(rvalid), .rdata(rdata)
    );

    function automatic logic [31:0] f_tick_next(input logic [31:0] t);
        return (t == TMAX) ? 32'd1 : t + 32'd1;
    endfunction

    function automatic logic [31:0] f_lock_next(input logic [31:0] s, input logic [31:0] w);
        if (w == 0) return 32'd0;
        if (s == 0) return w;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", cyc, 100000);
            summary();
        end
    end

    // single access from port p; returns read data
    task automatic access(input int p, input bit w, input logic [7:0] o,
                          input logic [31:0] d, input string tag,
                          output logic [31:0] rd);
        @(negedge clk);
        req = '0;
        req[p] = 1'b1;
        wr[p] = w;
        offs[p*8 +: 8] = o;
        wdata[p*32 +: 32] = d;
        #1;
        chk(gnt == N'(1 << p), {tag, " R7 grant"}, 32'(gnt), 32'(1 << p));
        @(negedge clk);
        req = '0;
        if (!w)
            chk(rvalid == N'(1 << p), {tag, " R8 rvalid"}, 32'(rvalid), 32'(1 << p));
        else
            chk(rvalid == '0, {tag, " R8 no rvalid on write"}, 32'(rvalid), 0);
        rd = rdata;
    endtask

    task automatic rd_tick(input int p, input string tag, output logic [31:0] got);
        access(p, 1'b0, 8'h08, 32'd0, tag, got);
        chk(got == m_tick, {tag, " R2 ticket"}, got, m_tick);
        m_tick = f_tick_next(m_tick);
    endtask

    task automatic rd_lock(input int p, input string tag, output logic [31:0] got);
        access(p, 1'b0, 8'h0C, 32'd0, tag, got);
        chk(got == m_lock, {tag, " lock value"}, got, m_lock);
    endtask

    task automatic wr_lock(input int p, input logic [31:0] d, input string tag);
        logic [31:0] dummy;
        access(p, 1'b1, 8'h0C, d, tag, dummy);
        m_lock = f_lock_next(m_lock, d);
    endtask

    initial begin
        logic [31:0] g, t1, t2;
        m_tick = 32'd1;
        m_lock = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rvalid == '0, "R1 rvalid idle", 32'(rvalid), 0);
        rd_lock(1, "R1 lock reset", g);
        rd_tick(2, "R1 ticket reset", g);

        // R4 / R5 / R6 directed
        wr_lock(0, 32'h5, "R4 claim");
        rd_lock(0, "R4 readback", g);
        chk(g == 32'h5, "R4 owned", g, 32'h5);
        wr_lock(1, 32'h9, "R5 late claim");
        rd_lock(1, "R5 held kept", g);
        chk(g == 32'h5, "R5 held kept", g, 32'h5);
        wr_lock(2, 32'h0, "R6 release");
        rd_lock(2, "R6 freed", g);
        chk(g == 0, "R6 freed", g, 0);

        // R9 stray offsets
        access(1, 1'b1, 8'h08, 32'h7, "R9 ticket write", g);
        access(1, 1'b1, 8'h10, 32'h7, "R9 other write", g);
        access(2, 1'b0, 8'h04, 32'd0, "R9 other read", g);
        chk(g == 0, "R9 other read zero", g, 0);
        rd_lock(0, "R9 lock untouched", g);
        rd_tick(0, "R9 ticket untouched", g);

        // Interleaved claim: port 1 and port 2
        rd_tick(1, "R2 agent1 ticket", t1);
        rd_tick(2, "R2 agent2 ticket", t2);
        wr_lock(2, t2, "R4 agent2 claim");
        wr_lock(1, t1, "R5 agent1 claim");
        rd_lock(2, "R4 agent2 check", g);
        chk(g == t2, "R4 agent2 owns", g, t2);
        rd_lock(1, "R5 agent1 check", g);
        chk(g != t1, "R5 agent1 loses", g, t2);
        wr_lock(2, 32'd0, "R6 agent2 release");
        begin : retry
            bit owned = 1'b0;
            for (int k = 0; k < 16 && !owned; k++) begin
                rd_tick(1, "R2 retry ticket", t1);
                wr_lock(1, t1, "R4 retry claim");
                rd_lock(1, "R4 retry check", g);
                owned = (g == t1);
            end
            chk(owned, "R4 retry succeeds", 32'(owned), 1);
        end
        wr_lock(1, 32'd0, "R6 release after retry");

        // R7 collision: all ports write to a free lock
        @(negedge clk);
        req = '1;
        wr = '1;
        for (int i = 0; i < N; i++) begin
            offs[i*8 +: 8] = 8'h0C;
            wdata[i*32 +: 32] = 32'(i + 11);
        end
        #1;
        chk(gnt == 3'b001, "R7 collision first", 32'(gnt), 1);
        @(negedge clk);
        req[0] = 1'b0;
        #1;
        chk(gnt == 3'b010, "R7 collision second", 32'(gnt), 2);
        @(negedge clk);
        req[1] = 1'b0;
        #1;
        chk(gnt == 3'b100, "R7 collision third", 32'(gnt), 4);
        @(negedge clk);
        req = '0;
        wr = '0;
        m_lock = 32'd11;
        rd_lock(2, "R7 lowest port won", g);
        chk(g == 32'd11, "R7 lowest port won", g, 32'd11);
        wr_lock(0, 32'd0, "R6 release collision");

        // R3 wrap
        while (m_tick != TMAX) rd_tick(0, "R3 advance", g);
        rd_tick(0, "R3 top value", g);
        chk(g == TMAX, "R3 top value", g, TMAX);
        rd_tick(0, "R3 wraps to one", g);
        chk(g == 32'd1, "R3 wraps to one", g, 1);

        // constrained random
        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            int p;
            int op;
            p = int'($urandom_range(N - 1, 0));
            op = int'($urandom_range(4, 0));
            case (op)
                0: rd_tick(p, "R2 random ticket", g);
                1: rd_lock(p, "R4 random lock", g);
                2: wr_lock(p, $urandom_range(1) ? 32'd0 : $urandom, "R5 random write");
                3: wr_lock(p, m_tick, "R4 random claim");
                default: begin
                    access(p, 1'b0, 8'h14, 32'd0, "R9 random other", g);
                    chk(g == 0, "R9 random other zero", g, 0);
                end
            endcase
        end
        summary();
    end
endmodule